// File: doc/BRIEF.md
# Interlaced Field and Line Sequencer

This block steps an interlaced raster display through its fields and tells the pixel fetch logic which frame-buffer line belongs to the current scan line. Each vertical sync pulse ends one field and starts the next. Fields alternate between odd and even, and a pair of fields makes one frame. A field-identity pin reports the parity of the current field. A one-clock pulse marks the start of each new frame.

Two configuration inputs shape a frame. The first picks which parity leads the frame. The second picks the interlace style. In the sync-only style, both fields walk the same half-height set of lines. In the sync-and-video style, the fields interleave the rows of a full-height picture: odd rows in the odd field and even rows in the even field. The block samples both inputs only at reset and at a frame boundary, so a frame never mixes two settings.

The block has no data stream of its own. Every pin is a plain control or status signal with no handshake. The sync pulses are single-clock strobes supplied by the timing generator.

Top module: `ilace_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters the first field of a frame. `second_field` becomes 0, the in-field line count becomes 0 and `frame_start` becomes 0. Both configuration inputs are captured at this point.
- R2: Every `vsync_pls` ends the current field. After the first field comes the second field (`second_field`=1) with the opposite parity. After the second field, a new frame begins (`second_field`=0).
- R3: `field_pin` is 0 during an odd field and 1 during an even field.
- R4: When the captured order bit `cfg_even_first` is 0, the first field of a frame is odd. When it is 1, the first field is even.
- R5: Each `hsync_pls` raises the in-field line count by one. A `vsync_pls` clears it to 0. If neither pulse arrives, `line_idx` and `field_pin` do not change.
- R6: With the captured `cfg_video`=0 (sync-only style), `line_idx` equals the in-field count, running 0 to LINES-1 in both fields.
- R7: With the captured `cfg_video`=1 (sync-and-video style), `line_idx` is twice the count plus 1 in an odd field (1, 3, … 2·LINES-1). In an even field it is twice the count (0, 2, … 2·LINES-2).
- R8: Changes on `cfg_even_first` and `cfg_video` take effect only at the `vsync_pls` that ends a second field, or at reset.
- R9: `frame_start` is high for exactly one clock, in the cycle after the `vsync_pls` that begins a first field. It is never high at any other time.
- R10: Extra `hsync_pls` pulses hold the count at LINES-1 instead of wrapping.
- R11: If `vsync_pls` and `hsync_pls` arrive in the same cycle, the vertical pulse wins and the count goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vsync_pls | input | 1 | One-clock vertical sync strobe |
| hsync_pls | input | 1 | One-clock horizontal sync strobe |
| cfg_even_first | input | 1 | 1: each frame starts with the even field |
| cfg_video | input | 1 | 1: sync-and-video style; 0: sync-only style |
| field_pin | output | 1 | Field identity: 0 odd, 1 even |
| second_field | output | 1 | 1 while the second field of the frame is shown |
| frame_start | output | 1 | One-clock pulse at the start of a frame |
| line_idx | output | $clog2(LINES)+1 | Frame-buffer line for the current scan line |

## Verification
The bench changes the style and the order bit in the middle of a frame. A block that applied them at once would change the line numbering or the field parity in that same frame, and the checks would see it. The bench sends far more horizontal pulses than a field holds, so a counter that wraps would fall back to a low line number instead of holding 2·LINES-1 or 478. It fires both sync pulses in the same cycle, which exposes a block that gives the horizontal pulse priority. It also watches `frame_start` around the boundary between the first and second field, where a block that pulses on every vertical sync would be caught.

// File: rtl/ilace_pkg.sv
package ilace_pkg;
  typedef enum logic {
    FLD_ODD  = 1'b0,
    FLD_EVEN = 1'b1
  } field_e;

  typedef struct packed {
    logic even_first;
    logic video;
  } ilace_cfg_t;

  function automatic field_e lead_field(input logic even_first);
    return even_first ? FLD_EVEN : FLD_ODD;
  endfunction
endpackage

// File: rtl/ilace_field_ctrl.sv
module ilace_field_ctrl
  import ilace_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       vsync,
  input  ilace_cfg_t cfg_in,
  output field_e     fld,
  output logic       second,
  output ilace_cfg_t cfg_act,
  output logic       frm_start
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_act   <= cfg_in;
      fld       <= lead_field(cfg_in.even_first);
      second    <= 1'b0;
      frm_start <= 1'b0;
    end else begin
      frm_start <= 1'b0;
      if (vsync) begin
        if (second) begin
          // frame boundary: pick up new settings
          cfg_act   <= cfg_in;
          fld       <= lead_field(cfg_in.even_first);
          second    <= 1'b0;
          frm_start <= 1'b1;
        end else begin
          fld    <= (fld == FLD_ODD) ? FLD_EVEN : FLD_ODD;
          second <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ilace_line_ctr.sv
module ilace_line_ctr #(
  parameter int LINES = 240,
  localparam int CNT_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vsync,
  input  logic             hsync,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LINES - 1);

  always_ff @(posedge clk) begin
    if (rst || vsync) begin
      cnt <= '0;
    end else if (hsync && cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ilace_line_map.sv
module ilace_line_map
  import ilace_pkg::*;
#(
  parameter int LINES = 240,
  localparam int CNT_W = $clog2(LINES),
  localparam int LINE_W = CNT_W + 1
) (
  input  logic [CNT_W-1:0]  cnt,
  input  field_e            fld,
  input  logic              video,
  output logic [LINE_W-1:0] line
);
  logic odd_bit;
  assign odd_bit = (fld == FLD_ODD);

  always_comb begin
    if (video) line = {cnt, odd_bit};
    else       line = {1'b0, cnt};
  end
endmodule

// File: rtl/ilace_seq.sv
module ilace_seq
  import ilace_pkg::*;
#(
  parameter int LINES = 240,
  localparam int CNT_W = $clog2(LINES),
  localparam int LINE_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vsync_pls,
  input  logic              hsync_pls,
  input  logic              cfg_even_first,
  input  logic              cfg_video,
  output logic              field_pin,
  output logic              second_field,
  output logic              frame_start,
  output logic [LINE_W-1:0] line_idx
);
  ilace_cfg_t       cfg_raw;
  ilace_cfg_t       cfg_act;
  field_e           fld;
  logic [CNT_W-1:0] cnt;

  assign cfg_raw.even_first = cfg_even_first;
  assign cfg_raw.video      = cfg_video;

  ilace_field_ctrl u_field (
    .clk       (clk),
    .rst       (rst),
    .vsync     (vsync_pls),
    .cfg_in    (cfg_raw),
    .fld       (fld),
    .second    (second_field),
    .cfg_act   (cfg_act),
    .frm_start (frame_start)
  );

  ilace_line_ctr #(.LINES(LINES)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .vsync (vsync_pls),
    .hsync (hsync_pls),
    .cnt   (cnt)
  );

  ilace_line_map #(.LINES(LINES)) u_map (
    .cnt   (cnt),
    .fld   (fld),
    .video (cfg_act.video),
    .line  (line_idx)
  );

  assign field_pin = (fld == FLD_EVEN);
endmodule

// File: rtl/ilace_seq_chk.sv
module ilace_seq_chk #(
  parameter int LINES = 240,
  localparam int LINE_W = $clog2(LINES) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              vsync_pls,
  input logic              hsync_pls,
  input logic              field_pin,
  input logic              second_field,
  input logic              frame_start,
  input logic [LINE_W-1:0] line_idx
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!second_field && !frame_start));

  // R2
  field_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (vsync_pls && !second_field) |=> (second_field && (field_pin != $past(field_pin))));

  // R9
  frame_start_src_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> ($past(vsync_pls) && !second_field));

  // R9
  frame_start_single_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);

  // R11
  vsync_clear_chk: assert property (@(posedge clk) disable iff (rst)
    vsync_pls |=> (line_idx <= LINE_W'(1)));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!vsync_pls && !hsync_pls) |=> ($stable(line_idx) && $stable(field_pin)));

  // R10
  line_bound_chk: assert property (@(posedge clk) disable iff (rst)
    32'(line_idx) < 2 * LINES);
endmodule

bind ilace_seq ilace_seq_chk #(.LINES(LINES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .vsync_pls    (vsync_pls),
  .hsync_pls    (hsync_pls),
  .field_pin    (field_pin),
  .second_field (second_field),
  .frame_start  (frame_start),
  .line_idx     (line_idx)
);

// File: tb/ilace_seq_bench.sv
`timescale 1ns/1ps
module ilace_seq_bench;
  localparam int LINES = 240;
  localparam int LW = $clog2(LINES) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vs = 1'b0, hs = 1'b0, ord = 1'b0, vid = 1'b0;
  logic fpin, sec, fs;
  logic [LW-1:0] line;
  int compared = 0;
  int mismatched = 0;

  always #2.5 clk = ~clk;

  ilace_seq #(.LINES(LINES)) u_ilace_seq (
    .clk(clk), .rst(rst), .vsync_pls(vs), .hsync_pls(hs),
    .cfg_even_first(ord), .cfg_video(vid),
    .field_pin(fpin), .second_field(sec), .frame_start(fs), .line_idx(line)
  );

  task automatic chk(input string req, input int got, input int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic vpulse();
    vs = 1'b1; @(negedge clk); vs = 1'b0;
  endtask

  task automatic hpulses(input int n);
    for (int i = 0; i < n; i++) begin
      hs = 1'b1; @(negedge clk); hs = 1'b0;
    end
  endtask

  task automatic t_reset();
    ord = 1'b0; vid = 1'b0;
    do_reset();
    chk("R1 second", sec, 0); chk("R1 line", line, 0);
    chk("R1 fs", fs, 0); chk("R3/R4 odd first", fpin, 0);
  endtask

  task automatic t_sync_only();
    hpulses(3); chk("R5/R6 count", line, 3);
    vpulse();
    chk("R2 second", sec, 1); chk("R3 even pin", fpin, 1);
    chk("R5 clear", line, 0); chk("R9 no fs mid frame", fs, 0);
    hpulses(LINES + 10); chk("R10 saturate", line, LINES - 1);
    vpulse();
    chk("R2 new frame", sec, 0); chk("R9 fs", fs, 1); chk("R3 odd pin", fpin, 0);
    @(negedge clk); chk("R9 fs one clock", fs, 0);
  endtask

  task automatic t_video();
    vid = 1'b1;
    hpulses(2); chk("R8 mode held", line, 2);
    vpulse(); hpulses(2); chk("R8 mode held second", line, 2);
    vpulse(); chk("R7 odd first line", line, 1);
    hpulses(3); chk("R7 odd line", line, 7);
    vpulse(); chk("R7 even first line", line, 0);
    hpulses(3); chk("R7 even line", line, 6);
    hpulses(LINES); chk("R7/R10 even last", line, 2 * LINES - 2);
    vpulse(); hpulses(LINES + 5); chk("R7/R10 odd last", line, 2 * LINES - 1);
  endtask

  task automatic t_order();
    ord = 1'b1;
    vpulse(); chk("R8 order held", fpin, 1); chk("R8 second", sec, 1);
    vpulse();
    chk("R4 even first", fpin, 1); chk("R4 first", sec, 0); chk("R9 fs", fs, 1);
    vpulse(); chk("R4 odd second", fpin, 0); chk("R7 odd line", line, 1);
    vpulse(); chk("R4 even again", fpin, 1);
  endtask

  task automatic t_same_cycle();
    hpulses(2); chk("R7 even count", line, 4);
    vs = 1'b1; hs = 1'b1; @(negedge clk); vs = 1'b0; hs = 1'b0;
    chk("R11 vsync wins", line, 1); chk("R11 field", fpin, 0);
  endtask

  task automatic t_idle();
    logic [LW-1:0] ln;
    ln = line;
    for (int i = 0; i < 8; i++) begin
      vid = ~vid; ord = ~ord; @(negedge clk);
    end
    chk("R5 idle line", line, ln); chk("R5 idle field", fpin, 0);
  endtask

  task automatic t_reset_order();
    ord = 1'b1; vid = 1'b0;
    do_reset();
    chk("R1/R4 even lead", fpin, 1); chk("R1 line", line, 0); chk("R1 fs", fs, 0);
    vpulse(); chk("R9 no fs", fs, 0); chk("R2 odd", fpin, 0);
  endtask

  initial begin
    t_reset();
    t_sync_only();
    t_video();
    t_order();
    t_same_cycle();
    t_idle();
    t_reset_order();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #500000;
    compared++; mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule